// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit

This block moves 36-bit words from a write port on one clock to a read port on a second clock. The two clocks may be unrelated or the same. The write pointer is passed to the read side as a Gray code value through a two-flop synchronizer, and the read-side release pointer is passed back the same way.

The read side works in first-word-fall-through style. When `outputReady` is high, the oldest unread word already sits on `rdData`, and a qualified read consumes it. Each port accepts a command only when its chip select is low, its enable is high and its direction input selects that port's operation.

A retransmit facility lets the reader mark the word currently on the output. While the mark is held, the reader can jump back to the marked word and read the same sequence again. During that time the writer is stopped before it could overwrite any word from the mark onward.

Top module: `xclk_rt_fifo`

## Requirements
- R1: A word is stored only on a `wrClk` rising edge where `wrCsN` is low, `wrEn` is high, `wrDir` is high and `inputReady` is high. Words leave the read port in the order they were stored, and none is lost or duplicated outside retransmit.
- R2: `inputReady` goes low once the FIFO holds 2^ADDR_W words, counting the word in the output register. A write attempted while it is low stores nothing and changes no stored word.
- R3: While `rstN` is low, `inputReady` and `outputReady` are low. `inputReady` rises on the first `wrClk` edge after `rstN` is released.
- R4: With coincident clocks, a word written into an empty FIFO raises `outputReady` on the third `rdClk` rising edge after the write edge. While `outputReady` stays high without a read, `rdData` is stable. A read needs `rdCsN` low, `rdEn` high, `rdDir` high and `outputReady` high.
- R5: A read attempted while `outputReady` is low consumes nothing.
- R6: A `rdClk` edge with `rtmMode` high and `outputReady` high, while not yet in retransmit, marks the word on `rdData` and enters retransmit. The mark does not move while `rtmMode` stays high.
- R7: The first `rdClk` edge with `rtmMode` low leaves retransmit. After that, `rdFromMark` has no effect.
- R8: In retransmit, a `rdClk` edge with `rdFromMark` high puts the marked word on `rdData` with `outputReady` high, even if a read was requested on the same edge. Later reads continue in order from the word after the mark.
- R9: In retransmit, writes are accepted only until the words from the mark to the newest word number 2^ADDR_W. The marked word stays intact.
- R10: The write pointer and the release pointer that cross clock domains change at most one bit per cycle of their own clock.
- R11: After leaving retransmit, space freed by earlier reads becomes writable again, and `inputReady` returns high within a few cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous active-low reset for both sides |
| wrCsN | input | 1 | Write port select, active low |
| wrEn | input | 1 | Write port enable |
| wrDir | input | 1 | 1 selects a write on the write port |
| wrData | input | DATA_W | Word to store |
| inputReady | output | 1 | High when a write will be accepted |
| rdCsN | input | 1 | Read port select, active low |
| rdEn | input | 1 | Read port enable |
| rdDir | input | 1 | 1 selects a read on the read port |
| rdData | output | DATA_W | Output register holding the oldest unread word |
| outputReady | output | 1 | High when `rdData` holds a valid word |
| rtmMode | input | 1 | Holds retransmit mode; a rising use marks the current word |
| rdFromMark | input | 1 | In retransmit, rewinds the read side to the marked word |

## Verification
A single word written into an empty FIFO checks the exact fall-through latency, separately from throughput. Continuous writes with the reader idle find the exact full boundary, then keep writing to show that blocked writes leave the stored data alone. A directed mark, read-on and rewind sequence tells a correct rewind apart from a stale or shifted pointer. Filling while the mark is held, then releasing it, shows that the write limit follows the mark rather than the read pointer. Long random traffic with randomly dropped select, enable and direction bits, and random mark and rewind toggling, compares every presented word against a reference model of the order the words should leave in.

// File: rtl/xclk_rt_fifo_pkg.sv
package xclk_rt_fifo_pkg;
  // Strobes from control to datapath; wrStrobe lives in the write clock
  // domain, loadOut in the read clock domain.
  typedef struct packed {
    logic wrStrobe;
    logic loadOut;
  } fifoStrobe_t;
endpackage

// File: rtl/xclk_rt_fifo_sync.sv
module xclk_rt_fifo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/xclk_rt_fifo_datapath.sv
module xclk_rt_fifo_datapath
  import xclk_rt_fifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 10
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrStrobe) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)               rdData <= '0;
    else if (strobe.loadOut) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/xclk_rt_fifo_ctrl.sv
module xclk_rt_fifo_ctrl
  import xclk_rt_fifo_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic              rdReq,
  input  logic              rtmMode,
  input  logic              rdFromMark,
  output fifoStrobe_t       strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              inputReady,
  output logic              outputReady,
  output logic              rtActive,
  output logic [ADDR_W:0]   wrGray,
  output logic [ADDR_W:0]   limitGray
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write clock domain ----------------
  logic [PTR_W-1:0] wrBin, wrBinNext, limitGraySync, limitBinSync;
  logic             doWrite, fullNext;

  xclk_rt_fifo_sync #(.W(PTR_W), .STAGES(2)) u_limitSync (
    .clk (wrClk),
    .rstN(rstN),
    .din (limitGray),
    .dout(limitGraySync)
  );

  assign limitBinSync = gray2bin(limitGraySync);
  assign doWrite      = wrReq & inputReady;
  assign wrBinNext    = wrBin + PTR_W'(doWrite);
  assign fullNext     = (wrBinNext - limitBinSync) == DEPTH_P;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin      <= '0;
      wrGray     <= '0;
      inputReady <= 1'b0;
    end else begin
      wrBin      <= wrBinNext;
      wrGray     <= bin2gray(wrBinNext);
      inputReady <= !fullNext;
    end
  end

  assign wrAddr          = wrBin[ADDR_W-1:0];
  assign strobe.wrStrobe = doWrite;

  // ---------------- read clock domain ----------------
  logic [PTR_W-1:0] rdBin, rdBinNext, markBin, limitBin, limitBinNext, limitTarget;
  logic [PTR_W-1:0] wrGraySync, wrBinSync;
  logic             readCmd, reload, memHasData, loadOut, orNext;

  xclk_rt_fifo_sync #(.W(PTR_W), .STAGES(2)) u_wrSync (
    .clk (rdClk),
    .rstN(rstN),
    .din (wrGray),
    .dout(wrGraySync)
  );

  assign wrBinSync  = gray2bin(wrGraySync);
  assign readCmd    = rdReq & outputReady;
  assign reload     = rtActive & rdFromMark;
  assign memHasData = rdBin != wrBinSync;
  assign loadOut    = reload | (memHasData & (!outputReady | readCmd));

  always_comb begin
    if (reload) begin
      rdAddr    = markBin[ADDR_W-1:0];
      rdBinNext = markBin + PTR_W'(1);
      orNext    = 1'b1;
    end else begin
      rdAddr    = rdBin[ADDR_W-1:0];
      rdBinNext = loadOut ? rdBin + PTR_W'(1) : rdBin;
      orNext    = loadOut ? 1'b1 : (readCmd ? 1'b0 : outputReady);
    end
  end

  // The release pointer only moves forward, one step per cycle, so its Gray
  // code never changes by more than one bit even when the target jumps.
  assign limitTarget  = rtActive ? markBin : (rdBin - PTR_W'(outputReady));
  assign limitBinNext = (limitBin != limitTarget) ? limitBin + PTR_W'(1) : limitBin;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin       <= '0;
      outputReady <= 1'b0;
      rtActive    <= 1'b0;
      markBin     <= '0;
      limitBin    <= '0;
      limitGray   <= '0;
    end else begin
      rdBin       <= rdBinNext;
      outputReady <= orNext;
      limitBin    <= limitBinNext;
      limitGray   <= bin2gray(limitBinNext);
      if (!rtmMode) begin
        rtActive <= 1'b0;
      end else if (!rtActive && outputReady) begin
        rtActive <= 1'b1;
        markBin  <= rdBin - PTR_W'(1);
      end
    end
  end

  assign strobe.loadOut = loadOut;
endmodule

// File: rtl/xclk_rt_fifo.sv
module xclk_rt_fifo
  import xclk_rt_fifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 10
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrCsN,
  input  logic              wrEn,
  input  logic              wrDir,
  input  logic [DATA_W-1:0] wrData,
  output logic              inputReady,
  input  logic              rdCsN,
  input  logic              rdEn,
  input  logic              rdDir,
  output logic [DATA_W-1:0] rdData,
  output logic              outputReady,
  input  logic              rtmMode,
  input  logic              rdFromMark
);
  fifoStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [ADDR_W:0]   wrGray, limitGray;
  logic              rtActive, wrReq, rdReq;

  assign wrReq = !wrCsN & wrEn & wrDir;
  assign rdReq = !rdCsN & rdEn & rdDir;

  xclk_rt_fifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrClk      (wrClk),
    .rdClk      (rdClk),
    .rstN       (rstN),
    .wrReq      (wrReq),
    .rdReq      (rdReq),
    .rtmMode    (rtmMode),
    .rdFromMark (rdFromMark),
    .strobe     (strobe),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .inputReady (inputReady),
    .outputReady(outputReady),
    .rtActive   (rtActive),
    .wrGray     (wrGray),
    .limitGray  (limitGray)
  );

  xclk_rt_fifo_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrAddr(wrAddr),
    .rdAddr(rdAddr),
    .wrData(wrData),
    .rdData(rdData)
  );
endmodule

// File: rtl/xclk_rt_fifo_chk.sv
module xclk_rt_fifo_chk #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 10
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              wrCsN,
  input logic              wrEn,
  input logic              wrDir,
  input logic              inputReady,
  input logic              rdCsN,
  input logic              rdEn,
  input logic              rdDir,
  input logic [DATA_W-1:0] rdData,
  input logic              outputReady,
  input logic              rtmMode,
  input logic              rdFromMark,
  input logic              rtActive,
  input logic [ADDR_W:0]   wrGray,
  input logic [ADDR_W:0]   limitGray
);
  logic wantWrite, wantRead;
  assign wantWrite = !wrCsN && wrEn && wrDir;
  assign wantRead  = !rdCsN && rdEn && rdDir;

  // R2
  blocked_write_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (wantWrite && !inputReady) |=> $stable(wrGray));

  // R10
  wr_gray_step_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  // R10
  limit_gray_step_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    $countones(limitGray ^ $past(limitGray)) <= 1);

  // R4
  out_hold_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (outputReady && !wantRead && !(rtActive && rdFromMark)) |=> (outputReady && $stable(rdData)));

  // R6
  mark_enter_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (rtmMode && outputReady) |=> rtActive);

  // R7
  mark_leave_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    !rtmMode |=> !rtActive);

  // R8
  rewind_ready_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (rtActive && rdFromMark) |=> outputReady);
endmodule

bind xclk_rt_fifo xclk_rt_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wrClk      (wrClk),
  .rdClk      (rdClk),
  .rstN       (rstN),
  .wrCsN      (wrCsN),
  .wrEn       (wrEn),
  .wrDir      (wrDir),
  .inputReady (inputReady),
  .rdCsN      (rdCsN),
  .rdEn       (rdEn),
  .rdDir      (rdDir),
  .rdData     (rdData),
  .outputReady(outputReady),
  .rtmMode    (rtmMode),
  .rdFromMark (rdFromMark),
  .rtActive   (rtActive),
  .wrGray     (wrGray),
  .limitGray  (limitGray)
);

// File: tb/xclk_rt_fifo_tb.sv
module xclk_rt_fifo_tb;
  localparam int DATA_W = 36;
  localparam int ADDR_W = 5;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int MS     = 256;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrCsN = 1'b1, wrEn = 1'b0, wrDir = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic              inputReady;
  logic              rdCsN = 1'b1, rdEn = 1'b0, rdDir = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic              outputReady;
  logic              rtmMode = 1'b0, rdFromMark = 1'b0;

  always #5 clk = ~clk;

  xclk_rt_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .wrClk(clk), .rdClk(clk), .rstN(rstN),
    .wrCsN(wrCsN), .wrEn(wrEn), .wrDir(wrDir), .wrData(wrData), .inputReady(inputReady),
    .rdCsN(rdCsN), .rdEn(rdEn), .rdDir(rdDir), .rdData(rdData), .outputReady(outputReady),
    .rtmMode(rtmMode), .rdFromMark(rdFromMark)
  );

  int checks = 0, fails = 0;
  logic [DATA_W-1:0] mMem [MS];
  int wrCount = 0, nextIdx = 0, markIdx = 0, seqNo = 0;
  bit mRt = 1'b0;

  function automatic logic [DATA_W-1:0] mkWord(input int n);
    logic [31:0] m;
    m = 32'(n) * 32'h9E3779B1;
    return {4'(n % 13), m};
  endfunction

  function automatic logic [DATA_W-1:0] expWord(input int idx);
    return mMem[idx % MS];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setWrite(input bit on);
    wrCsN = !on; wrEn = on; wrDir = on;
    wrData = mkWord(seqNo++);
  endtask

  task automatic setRead(input bit on);
    rdCsN = !on; rdEn = on; rdDir = on;
  endtask

  // One clock: update the reference model from inputs and outputs seen
  // before the edge, then check the outputs after it.
  task automatic cycle();
    bit wrOk, rdOk, reload;
    int oldNext;
    wrOk    = !wrCsN && wrEn && wrDir && inputReady;
    rdOk    = !rdCsN && rdEn && rdDir && outputReady;
    reload  = mRt && rdFromMark;
    oldNext = nextIdx;
    if (wrOk) begin mMem[wrCount % MS] = wrData; wrCount++; end
    if (reload) nextIdx = markIdx;
    else if (rdOk) nextIdx++;
    if (!rtmMode) mRt = 1'b0;
    else if (!mRt && outputReady) begin mRt = 1'b1; markIdx = oldNext; end
    @(posedge clk);
    @(negedge clk);
    if (outputReady) begin
      // R1 and R4: presented word is the next one in order
      check(rdData == expWord(nextIdx) && nextIdx < wrCount, "R1", longint'(rdData), longint'(expWord(nextIdx)));
    end
    // R9 and R2: nothing outstanding was overwritten
    check((wrCount - (mRt ? markIdx : nextIdx)) <= DEPTH, "R9",
          longint'(wrCount - (mRt ? markIdx : nextIdx)), longint'(DEPTH));
    if (wrData == rdData) wrData = mkWord(seqNo++);
  endtask

  task automatic drain();
    rtmMode = 1'b0; rdFromMark = 1'b0; setWrite(1'b0); setRead(1'b1);
    for (int i = 0; i < 400 && nextIdx < wrCount; i++) cycle();
    setRead(1'b0);
    check(nextIdx == wrCount, "R1", longint'(nextIdx), longint'(wrCount));
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int accepted;
    int mk;
    logic [DATA_W-1:0] held;
    void'($urandom(32'd20240611));

    // Reset
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(inputReady == 1'b0, "R3", longint'(inputReady), 0);
    check(outputReady == 1'b0, "R3", longint'(outputReady), 0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    check(inputReady == 1'b1, "R3", longint'(inputReady), 1);

    // R5: reads while empty consume nothing
    setRead(1'b1);
    repeat (3) cycle();
    check(outputReady == 1'b0, "R5", longint'(outputReady), 0);
    setRead(1'b0);

    // R4: fall-through latency of one word into an empty FIFO
    setWrite(1'b1);
    cycle();
    setWrite(1'b0);
    check(outputReady == 1'b0, "R4", longint'(outputReady), 0);
    cycle();
    check(outputReady == 1'b0, "R4", longint'(outputReady), 0);
    cycle();
    check(outputReady == 1'b0, "R4", longint'(outputReady), 0);
    cycle();
    check(outputReady == 1'b1 && rdData == expWord(0), "R4", longint'(rdData), longint'(expWord(0)));
    drain();

    // R2: fill with the reader idle, keep writing while blocked
    accepted = 0;
    for (int i = 0; i < DEPTH + 6; i++) begin
      setWrite(1'b1);
      if (inputReady) accepted++;
      cycle();
    end
    setWrite(1'b0);
    check(accepted == DEPTH, "R2", longint'(accepted), longint'(DEPTH));
    check(inputReady == 1'b0, "R2", longint'(inputReady), 0);
    drain();

    // R6, R8: mark, read on, rewind with a read on the same edge
    for (int i = 0; i < 10; i++) begin setWrite(1'b1); cycle(); end
    setWrite(1'b0);
    repeat (4) cycle();
    setRead(1'b1);
    repeat (3) cycle();
    setRead(1'b0);
    rtmMode = 1'b1;
    held = rdData;
    cycle();
    mk = markIdx;
    check(mRt && rdData == held, "R6", longint'(rdData), longint'(held));
    setRead(1'b1);
    repeat (4) cycle();
    rdFromMark = 1'b1;
    cycle();
    rdFromMark = 1'b0;
    setRead(1'b0);
    check(outputReady && rdData == expWord(mk), "R8", longint'(rdData), longint'(expWord(mk)));
    setRead(1'b1);
    repeat (2) cycle();
    check(nextIdx == mk + 2, "R8", longint'(nextIdx), longint'(mk + 2));

    // R9: fill while the mark is held
    repeat (12) cycle();
    setRead(1'b0);
    repeat (6) cycle();
    for (int i = 0; i < DEPTH + 5; i++) begin setWrite(1'b1); cycle(); end
    setWrite(1'b0);
    check(wrCount - mk == DEPTH, "R9", longint'(wrCount - mk), longint'(DEPTH));
    check(inputReady == 1'b0, "R9", longint'(inputReady), 0);
    rdFromMark = 1'b1;
    cycle();
    rdFromMark = 1'b0;
    check(rdData == expWord(mk), "R9", longint'(rdData), longint'(expWord(mk)));

    // R7, R11: leave retransmit, rewind ignored, space returns
    rtmMode = 1'b0;
    cycle();
    setRead(1'b1);
    repeat (5) cycle();
    setRead(1'b0);
    held = rdData;
    rdFromMark = 1'b1;
    cycle();
    rdFromMark = 1'b0;
    check(rdData == held, "R7", longint'(rdData), longint'(held));
    repeat (10) cycle();
    check(inputReady == 1'b1, "R11", longint'(inputReady), 1);
    drain();

    // Random traffic with mixed qualifiers and retransmit use
    for (int i = 0; i < 4000; i++) begin
      wrCsN = ($urandom % 8) == 0;
      wrEn  = ($urandom % 4) != 0;
      wrDir = ($urandom % 8) != 0;
      wrData = mkWord(seqNo++);
      rdCsN = ($urandom % 8) == 0;
      rdEn  = ($urandom % 3) != 0;
      rdDir = ($urandom % 8) != 0;
      rdFromMark = ($urandom % 40) == 0;
      if (($urandom % 60) == 0) rtmMode = !rtmMode;
      cycle();
    end
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule